// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Pin Gating

This block is the test access port of a chip: a sixteen-state controller clocked by the test clock and steered by the mode-select input, a 6-bit instruction path, a 1-bit bypass path and a 32-bit identification path. It drives a serial test output, and from the active instruction it produces two pin-control outputs. One hands the functional pins to the boundary path. The other disconnects every pin. It also selects the external boundary chain, whose serial return comes back in on an input.

The current controller state is exported as a 16-bit one-hot vector, so that monitoring logic can see any departure from the reset state, for example one caused by noise on the test clock or mode-select pins. Two sources return the controller to its reset state: an asynchronous active-low test reset, and a software reset request that is sampled on the rising test-clock edge.

The controller states and their vector bits are: Reset (bit 0), Idle (bit 1), Select-DR (bit 2), Capture-DR (bit 3), Shift-DR (bit 4), Exit1-DR (bit 5), Pause-DR (bit 6), Exit2-DR (bit 7), Update-DR (bit 8), Select-IR (bit 9), Capture-IR (bit 10), Shift-IR (bit 11), Exit1-IR (bit 12), Pause-IR (bit 13), Exit2-IR (bit 14) and Update-IR (bit 15). The transitions, given as the state reached for mode-select 0 and for mode-select 1, are:

- Reset: Idle / Reset
- Idle: Idle / Select-DR
- Select-DR: Capture-DR / Select-IR
- Capture-xR: Shift-xR / Exit1-xR
- Shift-xR: Shift-xR / Exit1-xR
- Exit1-xR: Pause-xR / Update-xR
- Pause-xR: Pause-xR / Exit2-xR
- Exit2-xR: Shift-xR / Update-xR
- Update-xR: Idle / Select-DR
- Select-IR: Capture-IR / Reset

Top module: `jtag_tap_gate`

## Requirements
- R1: After test reset the state vector is 16'h0001, and at every moment exactly one of its bits is set, at the bit positions given above.
- R2: The controller moves on each rising test-clock edge according to the transition list above, whatever the source of the toggles.
- R3: Five consecutive rising edges with mode-select high reach the Reset state from any state.
- R4: Entering Reset, or applying test reset, makes IDCODE (6'b000100) the active instruction. IDCODE selects the identification path, which captures ID_VALUE in Capture-DR and shifts it out LSB first.
- R5: In Capture-IR the instruction shifter loads 6'b000001. It shifts LSB first, with the input bit entering at the MSB.
- R6: EXTEST (6'b011000) asserts pin_gate and leaves pins_off low. HIGHZ (6'b011110) asserts pins_off and leaves pin_gate low. The two are never high together.
- R7: A shifted instruction becomes active only at the falling edge in Update-IR. The pin controls keep their old value during shifting, in Exit1-IR and at the rising edge into Update-IR.
- R8: BYPASS (6'b111111), the all-zero opcode, and any opcode not listed select the 1-bit bypass path, which captures 0. None of them touches the pin controls.
- R9: SAMPLE/PRELOAD (6'b011011) and EXTEST select the boundary chain: bs_sel is high and tdo carries bs_ret during Shift-DR. SAMPLE/PRELOAD leaves both pin controls low.
- R10: A software reset request sampled high at a rising edge puts the controller in Reset at that edge.
- R11: tdo and tdo_en change on the falling test-clock edge. tdo_en is high only while the controller is in Shift-DR or Shift-IR, and tdo is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| sw_rst_req | input | 1 | Synchronous software reset request |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial test data in |
| bs_ret | input | 1 | Serial return from the external boundary chain |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for tdo |
| state_vec | output | 16 | One-hot controller state |
| pin_gate | output | 1 | Hands the functional pins to the boundary path |
| pins_off | output | 1 | Disconnects all pins |
| bs_sel | output | 1 | Boundary chain is the selected data path |

## Verification
The bench builds the block with its default parameters: a 6-bit instruction and a 32-bit identification value of 32'h1B2C_E02F, with bit 0 set. Thirty-two shift cycles therefore read back the whole capture value, which exercises every bit of the identification path. The 6-bit width makes the opcode set exact. This includes the all-zero code and an unlisted code (6'b101010), which must both fall back to bypass. It also makes the capture pattern 6'b000001 visible bit by bit on tdo.

// File: rtl/tap_gate_pkg.sv
package tap_gate_pkg;

    localparam int IR_W     = 6;
    localparam int N_STATES = 16;
    localparam int ST_W     = $clog2(N_STATES);

    // Encoding value equals the bit index in the one-hot state vector
    typedef enum logic [ST_W-1:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SH_DR  = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SH_IR  = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS   = 2'd0,
        PATH_IDENT    = 2'd1,
        PATH_BOUNDARY = 2'd2
    } dr_path_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 6'b011000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 6'b011011;
    localparam logic [IR_W-1:0] OP_BYPASS  = 6'b111111;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 6'b011110;
    localparam logic [IR_W-1:0] OP_IDCODE  = 6'b000100;
    localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_gate_pkg::*;
(
    input  logic                tck,
    input  logic                trst_n,
    input  logic                sw_rst_req,
    input  logic                tms,
    output tap_state_e          state,
    output logic [N_STATES-1:0] state_vec
);

    tap_state_e state_q;
    tap_state_e state_d;

    // State register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (sw_rst_req) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
                ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
                ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
                ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
                ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
                ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
                ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
                ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
                ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
                ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
                ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
                ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
                ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
                ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
                ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
                ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
                default:   state_d = ST_RESET;
            endcase
        end
    end

    assign state = state_q;

    // One-hot view of the state
    for (genvar gi = 0; gi < N_STATES; gi++) begin : g_vec
        assign state_vec[gi] = (state_q == tap_state_e'(gi));
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_gate_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_active,
    output logic            ir_so
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_q;

    // Capture and shift on the rising edge
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= IR_CAPTURE;
        end else begin
            unique case (state)
                ST_CAP_IR: ir_sh <= IR_CAPTURE;
                ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                default:   ir_sh <= ir_sh;
            endcase
        end
    end

    // Update on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q <= OP_IDCODE;
        end else begin
            unique case (state)
                ST_RESET:  ir_q <= OP_IDCODE;
                ST_UPD_IR: ir_q <= ir_sh;
                default:   ir_q <= ir_q;
            endcase
        end
    end

    assign ir_active = ir_q;
    assign ir_so     = ir_sh[0];

endmodule

// File: rtl/tap_decode.sv
module tap_decode
    import tap_gate_pkg::*;
(
    input  logic [IR_W-1:0] ir_active,
    output dr_path_e        path,
    output logic            pin_gate,
    output logic            pins_off
);

    always_comb begin
        path     = PATH_BYPASS;
        pin_gate = 1'b0;
        pins_off = 1'b0;
        case (ir_active)
            OP_EXTEST: begin
                path     = PATH_BOUNDARY;
                pin_gate = 1'b1;
            end
            OP_SAMPLE: begin
                path = PATH_BOUNDARY;
            end
            OP_HIGHZ: begin
                pins_off = 1'b1;
            end
            OP_IDCODE: begin
                path = PATH_IDENT;
            end
            default: begin
                path = PATH_BYPASS;
            end
        endcase
    end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_gate_pkg::*;
#(
    parameter int               ID_W     = 32,
    parameter logic [ID_W-1:0]  ID_VALUE = 32'h1B2C_E02F
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       tdi,
    input  logic       bs_ret,
    output logic       dr_so
);

    logic            byp_q;
    logic [ID_W-1:0] id_sh;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
            id_sh <= ID_VALUE;
        end else begin
            unique case (state)
                ST_CAP_DR: begin
                    byp_q <= 1'b0;
                    id_sh <= ID_VALUE;
                end
                ST_SH_DR: begin
                    byp_q <= tdi;
                    if (path == PATH_IDENT) begin
                        id_sh <= {tdi, id_sh[ID_W-1:1]};
                    end
                end
                default: begin
                    byp_q <= byp_q;
                    id_sh <= id_sh;
                end
            endcase
        end
    end

    always_comb begin
        unique case (path)
            PATH_IDENT:    dr_so = id_sh[0];
            PATH_BOUNDARY: dr_so = bs_ret;
            default:       dr_so = byp_q;
        endcase
    end

endmodule

// File: rtl/jtag_tap_gate.sv
module jtag_tap_gate
    import tap_gate_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1B2C_E02F
) (
    input  logic        tck,
    input  logic        trst_n,
    input  logic        sw_rst_req,
    input  logic        tms,
    input  logic        tdi,
    input  logic        bs_ret,
    output logic        tdo,
    output logic        tdo_en,
    output logic [15:0] state_vec,
    output logic        pin_gate,
    output logic        pins_off,
    output logic        bs_sel
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_active;
    logic            ir_so;
    logic            dr_so;
    dr_path_e        path;
    logic            tdo_q;
    logic            tdo_en_q;

    tap_fsm u_fsm (
        .tck        (tck),
        .trst_n     (trst_n),
        .sw_rst_req (sw_rst_req),
        .tms        (tms),
        .state      (state),
        .state_vec  (state_vec)
    );

    tap_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .state     (state),
        .tdi       (tdi),
        .ir_active (ir_active),
        .ir_so     (ir_so)
    );

    tap_decode u_dec (
        .ir_active (ir_active),
        .path      (path),
        .pin_gate  (pin_gate),
        .pins_off  (pins_off)
    );

    tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .path   (path),
        .tdi    (tdi),
        .bs_ret (bs_ret),
        .dr_so  (dr_so)
    );

    // Output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q    <= 1'b0;
            tdo_en_q <= 1'b0;
        end else begin
            unique case (state)
                ST_SH_IR: begin
                    tdo_q    <= ir_so;
                    tdo_en_q <= 1'b1;
                end
                ST_SH_DR: begin
                    tdo_q    <= dr_so;
                    tdo_en_q <= 1'b1;
                end
                default: begin
                    tdo_q    <= 1'b0;
                    tdo_en_q <= 1'b0;
                end
            endcase
        end
    end

    assign tdo    = tdo_q;
    assign tdo_en = tdo_en_q;
    assign bs_sel = (path == PATH_BOUNDARY);

endmodule

// File: rtl/tap_gate_chk.sv
module tap_gate_chk (
    input logic        tck,
    input logic        trst_n,
    input logic        sw_rst_req,
    input logic        tms,
    input logic        tdo_en,
    input logic [15:0] state_vec,
    input logic        pin_gate,
    input logic        pins_off
);

    logic [2:0] ones_cnt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ones_cnt <= 3'd0;
        end else if (!tms) begin
            ones_cnt <= 3'd0;
        end else if (ones_cnt != 3'd5) begin
            ones_cnt <= ones_cnt + 3'd1;
        end
    end

    AST_STATE_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
        $countones(state_vec) == 1);                                        // R1

    AST_TMS_FIVE_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt == 3'd5) |-> (state_vec == 16'h0001));                    // R3

    AST_PIN_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
        !(pin_gate && pins_off));                                           // R6

    AST_PIN_CHANGE_POINT: assert property (@(posedge tck) disable iff (!trst_n)
        (!$stable(pin_gate) || !$stable(pins_off)) |-> (state_vec[15] || state_vec[0])); // R7

    AST_SW_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        sw_rst_req |=> (state_vec == 16'h0001));                            // R10

    AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_vec[4] || state_vec[11]));                        // R11

endmodule

bind jtag_tap_gate tap_gate_chk u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .sw_rst_req (sw_rst_req),
    .tms        (tms),
    .tdo_en     (tdo_en),
    .state_vec  (state_vec),
    .pin_gate   (pin_gate),
    .pins_off   (pins_off)
);

// File: tb/jtag_tap_gate_tb.sv
`timescale 1ns/100ps
module jtag_tap_gate_tb;

    localparam logic [31:0] ID_EXP = 32'h1B2C_E02F;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        sw_rst_req = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        bs_ret = 1'b0;
    logic        tdo;
    logic        tdo_en;
    logic [15:0] state_vec;
    logic        pin_gate;
    logic        pins_off;
    logic        bs_sel;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 tck = ~tck;

    jtag_tap_gate u_dut (
        .tck        (tck),
        .trst_n     (trst_n),
        .sw_rst_req (sw_rst_req),
        .tms        (tms),
        .tdi        (tdi),
        .bs_ret     (bs_ret),
        .tdo        (tdo),
        .tdo_en     (tdo_en),
        .state_vec  (state_vec),
        .pin_gate   (pin_gate),
        .pins_off   (pins_off),
        .bs_sel     (bs_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle; capture tdo/tdo_en after the falling edge
    task automatic tick(input logic m, input logic d, output logic seen, output logic seen_en);
        tms = m;
        tdi = d;
        @(negedge tck);
        #0.5;
        seen    = tdo;
        seen_en = tdo_en;
        @(posedge tck);
        #0.5;
    endtask

    task automatic step(input logic m);
        logic s, e;
        tick(m, 1'b0, s, e);
    endtask

    task automatic go_reset_idle();
        for (int i = 0; i < 5; i++) step(1'b1);
        step(1'b0);
    endtask

    // From Idle: load an opcode, end in Idle; returns the bits shifted out
    task automatic load_ir(input logic [5:0] op, output logic [5:0] out, input logic chk_hold,
                           input logic old_gate, input logic old_off);
        logic s, e;
        step(1'b1); step(1'b1); step(1'b0); step(1'b0);
        for (int i = 0; i < 6; i++) begin
            tick((i == 5), op[i], s, e);
            out[i] = s;
            if (chk_hold) check("R7 gate held while shifting", {31'd0, pin_gate}, {31'd0, old_gate});
        end
        step(1'b1);
        if (chk_hold) begin
            check("R7 gate held at Update-IR entry", {31'd0, pin_gate}, {31'd0, old_gate});
            check("R7 off held at Update-IR entry", {31'd0, pins_off}, {31'd0, old_off});
        end
        step(1'b0);
    endtask

    // From Idle: shift n DR bits, end in Idle
    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                            output logic all_en);
        logic s, e;
        dout   = '0;
        all_en = 1'b1;
        step(1'b1); step(1'b0); step(1'b0);
        for (int i = 0; i < n; i++) begin
            tick((i == n - 1), din[i], s, e);
            dout[i] = s;
            all_en &= e;
        end
        step(1'b1);
        step(1'b0);
    endtask

    task automatic t_reset_state();
        check("R1 reset vector", {16'd0, state_vec}, 32'h0001);
        check("R11 tdo_en low at reset", {31'd0, tdo_en}, 32'd0);
        check("R6 pin_gate low at reset", {31'd0, pin_gate}, 32'd0);
        check("R6 pins_off low at reset", {31'd0, pins_off}, 32'd0);
    endtask

    task automatic t_walk();
        logic [15:0] ev [19];
        logic        mv [19];
        logic s, e;
        mv = '{0,1,0,0,1,0,1,0,1,1,1,1,0,0,1,0,1,1,0};
        ev = '{16'h0002,16'h0004,16'h0008,16'h0010,16'h0020,16'h0040,16'h0080,16'h0010,
               16'h0020,16'h0100,16'h0004,16'h0200,16'h0400,16'h0800,16'h1000,16'h2000,
               16'h4000,16'h8000,16'h0002};
        for (int i = 0; i < 19; i++) begin
            tick(mv[i], 1'b0, s, e);
            check("R2 state walk", {16'd0, state_vec}, {16'd0, ev[i]});
        end
        step(1'b1); step(1'b1); step(1'b1);
        check("R2 Select-IR to Reset", {16'd0, state_vec}, 32'h0001);
    endtask

    task automatic t_five_ones();
        step(1'b0); step(1'b1); step(1'b1); step(1'b0); step(1'b0);
        check("R3 reached Shift-IR", {16'd0, state_vec}, 32'h0800);
        for (int i = 0; i < 5; i++) step(1'b1);
        check("R3 five ones from Shift-IR", {16'd0, state_vec}, 32'h0001);
        step(1'b0); step(1'b1); step(1'b0); step(1'b1); step(1'b0);
        check("R3 reached Pause-DR", {16'd0, state_vec}, 32'h0040);
        for (int i = 0; i < 5; i++) step(1'b1);
        check("R3 five ones from Pause-DR", {16'd0, state_vec}, 32'h0001);
    endtask

    task automatic t_idcode();
        logic [63:0] o;
        logic en;
        go_reset_idle();
        shift_dr(32, 64'd0, o, en);
        check("R4 identification value", o[31:0], ID_EXP);
        check("R11 tdo_en during Shift-DR", {31'd0, en}, 32'd1);
        check("R9 bs_sel low under IDCODE", {31'd0, bs_sel}, 32'd0);
    endtask

    task automatic t_capture_ir();
        logic [5:0] o;
        go_reset_idle();
        load_ir(6'b111111, o, 1'b0, 1'b0, 1'b0);
        check("R5 Capture-IR pattern", {26'd0, o}, 32'h01);
    endtask

    task automatic t_extest_highz();
        logic [5:0] o;
        go_reset_idle();
        load_ir(6'b011000, o, 1'b1, 1'b0, 1'b0);
        check("R6 EXTEST pin_gate", {31'd0, pin_gate}, 32'd1);
        check("R6 EXTEST pins_off", {31'd0, pins_off}, 32'd0);
        check("R9 EXTEST bs_sel", {31'd0, bs_sel}, 32'd1);
        load_ir(6'b011110, o, 1'b1, 1'b1, 1'b0);
        check("R6 HIGHZ pins_off", {31'd0, pins_off}, 32'd1);
        check("R6 HIGHZ pin_gate", {31'd0, pin_gate}, 32'd0);
    endtask

    task automatic t_bypass_codes();
        logic [5:0]  o;
        logic [63:0] d;
        logic        en;
        logic [5:0]  codes [3];
        codes = '{6'b111111, 6'b000000, 6'b101010};
        for (int k = 0; k < 3; k++) begin
            go_reset_idle();
            load_ir(codes[k], o, 1'b0, 1'b0, 1'b0);
            shift_dr(8, 64'hB2, d, en);
            check("R8 bypass one-cycle delay", {24'd0, d[7:0]}, 32'h64);
            check("R8 no pin_gate", {31'd0, pin_gate}, 32'd0);
            check("R8 no pins_off", {31'd0, pins_off}, 32'd0);
        end
    endtask

    task automatic t_sample();
        logic [5:0]  o;
        logic [63:0] d;
        logic        en;
        go_reset_idle();
        load_ir(6'b011011, o, 1'b0, 1'b0, 1'b0);
        check("R9 SAMPLE bs_sel", {31'd0, bs_sel}, 32'd1);
        bs_ret = 1'b1;
        shift_dr(4, 64'd0, d, en);
        bs_ret = 1'b0;
        check("R9 tdo carries bs_ret", {28'd0, d[3:0]}, 32'hF);
        check("R9 SAMPLE leaves pins", {30'd0, pin_gate, pins_off}, 32'd0);
        check("R11 tdo low in Idle", {31'd0, tdo}, 32'd0);
    endtask

    task automatic t_sw_reset();
        logic [5:0] o;
        go_reset_idle();
        load_ir(6'b011000, o, 1'b0, 1'b0, 1'b0);
        step(1'b1); step(1'b0); step(1'b0);
        sw_rst_req = 1'b1;
        step(1'b0);
        sw_rst_req = 1'b0;
        check("R10 software reset to Reset", {16'd0, state_vec}, 32'h0001);
        step(1'b1);
        check("R4 IDCODE restored on Reset entry", {31'd0, pin_gate}, 32'd0);
    endtask

    task automatic t_async_reset();
        logic [5:0] o;
        go_reset_idle();
        load_ir(6'b011110, o, 1'b0, 1'b0, 1'b0);
        step(1'b1);
        #1 trst_n = 1'b0;
        #1;
        check("R1 async reset vector", {16'd0, state_vec}, 32'h0001);
        check("R4 async reset clears HIGHZ", {31'd0, pins_off}, 32'd0);
        @(negedge tck);
        #1 trst_n = 1'b1;
        @(posedge tck);
        #0.5;
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #14 trst_n = 1'b1;
        @(posedge tck);
        #0.5;
        t_reset_state();
        t_walk();
        t_five_ones();
        t_idcode();
        t_capture_ir();
        t_extest_highz();
        t_bypass_codes();
        t_sample();
        t_sw_reset();
        t_async_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule